// File: doc/BRIEF.md
# AHB-Lite to APB Bridge

This block is the single-slave bridge between a system AHB-Lite bus and a peripheral APB bus. It runs wholly on the AHB clock. An enable input, `pclk_en`, pulses once every N clock cycles, where N is 1, 2, 4 or 8. The APB side moves only on edges where that enable is high, so the peripheral bus behaves as if clocked at 1/N of the system rate. Each accepted AHB transfer becomes exactly one APB transfer. The bridge holds the AHB side stalled until the APB access completes. It then returns OKAY with read data, or a two-cycle ERROR if the peripheral signals a slave error. Bursts are treated as independent single transfers.

The controller has six named states:
- ST_IDLE: ready, nothing pending.
- ST_PEND: accepted, waiting for an enable edge.
- ST_SETUP: APB select high, enable low.
- ST_ACCESS: APB enable high.
- ST_ERR1: first error cycle, still stalled.
- ST_ERR2: second error cycle, ready.

The transitions are:
- ST_IDLE→ST_PEND on acceptance.
- ST_PEND→ST_SETUP on an enable edge.
- ST_SETUP→ST_ACCESS on an enable edge.
- ST_ACCESS→ST_IDLE when the access completes without error. If early completion is used and a new transfer is accepted in the same cycle, this goes to ST_PEND instead.
- ST_ACCESS→ST_ERR1 when the access completes with an error.
- ST_ERR1→ST_ERR2 unconditionally.
- ST_ERR2→ST_IDLE, or ST_ERR2→ST_PEND if a new transfer is accepted.

An access completes on an enable edge where the peripheral reports ready.

The bridge derives the byte-lane strobes and the protection field from the captured size, address and protection bits. Read data can be registered (the default) or passed through. Write data can be passed through (the default) or registered.

Top module: `ahb_apb_bridge`

## Requirements
- R1: A transfer is accepted when `ahb_sel`=1, `ahb_ready_in`=1 and `ahb_trans` is 2'b10 or 2'b11. In the cycle after acceptance `ahb_readyout` is 0, and it stays 0 until the APB access completes. After reset `ahb_readyout` is 1.
- R2: Every APB transfer first shows a setup cycle (`apb_sel`=1, `apb_enable`=0) and then access cycles (`apb_enable`=1). `apb_sel` and `apb_enable` change only after a clock edge where `pclk_en` was 1.
- R3: The bridge stays in the access phase (`apb_enable`=1) as long as `apb_ready` is 0 or `pclk_en` is 0.
- R4: During the APB transfer, `apb_addr[ADDR_W-1:2]` equals the captured `ahb_addr[ADDR_W-1:2]` and `apb_addr[1:0]` is 0. `apb_write` equals the captured `ahb_write`.
- R5: For a write, `apb_strb` depends on the captured size and address. Size 2 (word) gives 4'b1111. Size 1 (halfword) gives 4'b0011 when addr[1]=0 and 4'b1100 when addr[1]=1. Size 0 (byte) gives a one-hot code in which addr[1:0]=k sets bit k.
- R6: For a read, `apb_strb` is 4'b0000.
- R7: `apb_prot` is {~HPROT[0], 1'b0, HPROT[1]}. Here `ahb_prot[1]` is the privileged bit and `ahb_prot[0]` is the data/opcode bit.
- R8: If `apb_slverr` is 1 at completion, the AHB side shows two cycles with `ahb_resp`=1: first with `ahb_readyout`=0, then with `ahb_readyout`=1. After that `ahb_resp` returns to 0. A completion without error gives `ahb_resp`=0.
- R9: With registered read data, one cycle after completion `ahb_readyout`=1 and `ahb_rdata` holds the `apb_rdata` value sampled at completion.
- R10: With pass-through write data, `apb_wdata` equals `ahb_wdata` during the APB transfer.
- R11: `apb_active` is 1 from acceptance until the APB access completes, and 0 when the bridge is idle.
- R12: If `ahb_sel`=0, or if `ahb_trans[1]`=0 (IDLE or BUSY), nothing is accepted. `ahb_readyout` stays 1, and `apb_sel` and `apb_active` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | AHB clock; all logic runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| pclk_en | input | 1 | APB step enable, high once every N cycles |
| ahb_sel | input | 1 | Slave select |
| ahb_addr | input | ADDR_W | Transfer address |
| ahb_trans | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| ahb_size | input | 3 | Transfer size (0 byte, 1 halfword, 2 word) |
| ahb_prot | input | 2 | Protection bits: [1] privileged, [0] data/opcode |
| ahb_write | input | 1 | 1 for write |
| ahb_ready_in | input | 1 | Bus-level ready from the AHB interconnect |
| ahb_wdata | input | DATA_W | Write data |
| ahb_readyout | output | 1 | Slave ready |
| ahb_rdata | output | DATA_W | Read data |
| ahb_resp | output | 1 | 1 = ERROR response |
| apb_addr | output | ADDR_W | APB address, word aligned |
| apb_sel | output | 1 | APB select |
| apb_enable | output | 1 | APB enable |
| apb_write | output | 1 | APB direction |
| apb_wdata | output | DATA_W | APB write data |
| apb_strb | output | DATA_W/8 | APB byte strobes |
| apb_prot | output | 3 | APB protection |
| apb_rdata | input | DATA_W | APB read data |
| apb_ready | input | 1 | APB slave ready |
| apb_slverr | input | 1 | APB slave error |
| apb_active | output | 1 | APB side busy, for clock gating |

## Verification
Most internal state errors in this block appear on the AHB and APB ports within one enable period. A controller that skips ST_SETUP or leaves ST_ACCESS early shows `apb_enable` without a preceding setup, or shows `apb_enable` dropping while ready is still low. A controller stuck in ST_PEND or ST_ERR1 shows `ahb_readyout` staying low. A wrong captured size, address or protection shows up in the very first setup cycle, as a bad strobe, address or protection value. The sweep runs every enable ratio, every legal size and address alignment, every protection combination, several wait-state counts and both error directions. Each expected strobe, address and response cycle is computed arithmetically in the bench.

// File: rtl/ahb_apb_bridge_pkg.sv
package ahb_apb_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND,
        ST_SETUP,
        ST_ACCESS,
        ST_ERR1,
        ST_ERR2
    } bridge_state_t;

    localparam logic [1:0] TRANS_NONSEQ = 2'b10;
    localparam logic [1:0] TRANS_SEQ    = 2'b11;

endpackage

// File: rtl/ahb_apb_bridge_xlate.sv
module ahb_apb_bridge_xlate #(
    parameter int LANES = 4,
    parameter int LO_W  = $clog2(LANES)
) (
    input  logic             is_write,
    input  logic [2:0]       size,
    input  logic [LO_W-1:0]  addr_lo,
    input  logic             prot_priv,
    input  logic             prot_data,
    output logic [LANES-1:0] strb,
    output logic [2:0]       pprot
);

    // A lane is enabled when it falls in the same size-aligned block as the address.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            logic [LO_W-1:0] lane;
            lane = LO_W'(i);
            strb[i] = is_write &&
                      ((32'(size) >= LO_W) || ((lane >> size) == (addr_lo >> size)));
        end
    end

    assign pprot = {~prot_data, 1'b0, prot_priv};

endmodule

// File: rtl/ahb_apb_bridge_fsm.sv
module ahb_apb_bridge_fsm
    import ahb_apb_bridge_pkg::*;
#(
    parameter bit EARLY_DONE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pclk_en,
    input  logic          accept,
    input  logic          apb_ready,
    input  logic          apb_slverr,
    output bridge_state_t state,
    output logic          done,
    output logic          psel,
    output logic          penable,
    output logic          readyout,
    output logic          resp,
    output logic          active
);

    bridge_state_t state_nx;

    assign done = (state == ST_ACCESS) && pclk_en && apb_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept)  state_nx = ST_PEND;
            ST_PEND:   if (pclk_en) state_nx = ST_SETUP;
            ST_SETUP:  if (pclk_en) state_nx = ST_ACCESS;
            ST_ACCESS: if (done) begin
                if (apb_slverr)  state_nx = ST_ERR1;
                else if (accept) state_nx = ST_PEND;
                else             state_nx = ST_IDLE;
            end
            ST_ERR1:   state_nx = ST_ERR2;
            ST_ERR2:   state_nx = accept ? ST_PEND : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        psel     = 1'b0;
        penable  = 1'b0;
        readyout = 1'b0;
        resp     = 1'b0;
        active   = 1'b0;
        unique case (state)
            ST_IDLE:   readyout = 1'b1;
            ST_PEND:   active = 1'b1;
            ST_SETUP: begin
                psel   = 1'b1;
                active = 1'b1;
            end
            ST_ACCESS: begin
                psel     = 1'b1;
                penable  = 1'b1;
                active   = 1'b1;
                readyout = EARLY_DONE && done && !apb_slverr;
            end
            ST_ERR1:   resp = 1'b1;
            ST_ERR2: begin
                resp     = 1'b1;
                readyout = 1'b1;
            end
            default:   readyout = 1'b1;
        endcase
    end

endmodule

// File: rtl/ahb_apb_bridge.sv
module ahb_apb_bridge
    import ahb_apb_bridge_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter bit REG_RDATA = 1'b1,
    parameter bit REG_WDATA = 1'b0,
    localparam int LANES    = DATA_W / 8,
    localparam int LO_W     = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk_en,
    input  logic              ahb_sel,
    input  logic [ADDR_W-1:0] ahb_addr,
    input  logic [1:0]        ahb_trans,
    input  logic [2:0]        ahb_size,
    input  logic [1:0]        ahb_prot,
    input  logic              ahb_write,
    input  logic              ahb_ready_in,
    input  logic [DATA_W-1:0] ahb_wdata,
    output logic              ahb_readyout,
    output logic [DATA_W-1:0] ahb_rdata,
    output logic              ahb_resp,
    output logic [ADDR_W-1:0] apb_addr,
    output logic              apb_sel,
    output logic              apb_enable,
    output logic              apb_write,
    output logic [DATA_W-1:0] apb_wdata,
    output logic [LANES-1:0]  apb_strb,
    output logic [2:0]        apb_prot,
    input  logic [DATA_W-1:0] apb_rdata,
    input  logic              apb_ready,
    input  logic              apb_slverr,
    output logic              apb_active
);

    bridge_state_t     state;
    logic              accept;
    logic              done;
    logic [ADDR_W-1:0] cap_addr;
    logic              cap_write;
    logic [2:0]        cap_size;
    logic [1:0]        cap_prot;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    assign accept = ahb_sel && ahb_ready_in &&
                    ((ahb_trans == TRANS_NONSEQ) || (ahb_trans == TRANS_SEQ));

    ahb_apb_bridge_fsm #(
        .EARLY_DONE (!REG_RDATA)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pclk_en    (pclk_en),
        .accept     (accept),
        .apb_ready  (apb_ready),
        .apb_slverr (apb_slverr),
        .state      (state),
        .done       (done),
        .psel       (apb_sel),
        .penable    (apb_enable),
        .readyout   (ahb_readyout),
        .resp       (ahb_resp),
        .active     (apb_active)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_write <= 1'b0;
            cap_size  <= '0;
            cap_prot  <= '0;
        end else if (accept) begin
            cap_addr  <= ahb_addr;
            cap_write <= ahb_write;
            cap_size  <= ahb_size;
            cap_prot  <= ahb_prot;
        end
    end

    ahb_apb_bridge_xlate #(
        .LANES (LANES),
        .LO_W  (LO_W)
    ) u_xlate (
        .is_write  (cap_write),
        .size      (cap_size),
        .addr_lo   (cap_addr[LO_W-1:0]),
        .prot_priv (cap_prot[1]),
        .prot_data (cap_prot[0]),
        .strb      (apb_strb),
        .pprot     (apb_prot)
    );

    assign apb_addr  = {cap_addr[ADDR_W-1:LO_W], {LO_W{1'b0}}};
    assign apb_write = cap_write;

    // Write data is valid on the AHB side while the bridge waits to start the APB transfer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 wdata_q <= '0;
        else if (state == ST_PEND)  wdata_q <= ahb_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata_q <= '0;
        else if (done) rdata_q <= apb_rdata;
    end

    assign apb_wdata = REG_WDATA ? wdata_q : ahb_wdata;
    assign ahb_rdata = REG_RDATA ? rdata_q : apb_rdata;

endmodule

// File: rtl/ahb_apb_bridge_checker.sv
module ahb_apb_bridge_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pclk_en,
    input logic             ahb_sel,
    input logic [1:0]       ahb_trans,
    input logic             ahb_ready_in,
    input logic             ahb_readyout,
    input logic             ahb_resp,
    input logic             apb_sel,
    input logic             apb_enable,
    input logic             apb_write,
    input logic [LANES-1:0] apb_strb,
    input logic             apb_ready,
    input logic             apb_active
);

    AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (ahb_sel && ahb_trans[1] && ahb_ready_in && ahb_readyout) |=> !ahb_readyout); // R1

    AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(apb_enable) |-> $past(apb_sel && !apb_enable && pclk_en)); // R2

    AST_APB_PACED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pclk_en) |-> ($stable(apb_sel) && $stable(apb_enable))); // R2

    AST_ACCESS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_enable && !(pclk_en && apb_ready)) |=> apb_enable); // R3

    AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_sel && !apb_write) |-> (apb_strb == '0)); // R6

    AST_ERR_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ahb_resp && !ahb_readyout) |=> (ahb_resp && ahb_readyout)); // R8

    AST_ACTIVE_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        apb_sel |-> apb_active); // R11

    AST_IGNORED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ahb_readyout && ahb_ready_in && !(ahb_sel && ahb_trans[1]) && !apb_active)
        |=> (ahb_readyout && !apb_active)); // R12

endmodule

bind ahb_apb_bridge ahb_apb_bridge_checker #(
    .LANES (LANES)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .pclk_en      (pclk_en),
    .ahb_sel      (ahb_sel),
    .ahb_trans    (ahb_trans),
    .ahb_ready_in (ahb_ready_in),
    .ahb_readyout (ahb_readyout),
    .ahb_resp     (ahb_resp),
    .apb_sel      (apb_sel),
    .apb_enable   (apb_enable),
    .apb_write    (apb_write),
    .apb_strb     (apb_strb),
    .apb_ready    (apb_ready),
    .apb_active   (apb_active)
);

// File: tb/ahb_apb_bridge_bench.sv
`timescale 1ns/1ps
module ahb_apb_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pclk_en;
    logic        ahb_sel;
    logic [15:0] ahb_addr;
    logic [1:0]  ahb_trans;
    logic [2:0]  ahb_size;
    logic [1:0]  ahb_prot;
    logic        ahb_write;
    logic        ahb_ready_in;
    logic [31:0] ahb_wdata;
    logic        ahb_readyout;
    logic [31:0] ahb_rdata;
    logic        ahb_resp;
    logic [15:0] apb_addr;
    logic        apb_sel;
    logic        apb_enable;
    logic        apb_write;
    logic [31:0] apb_wdata;
    logic [3:0]  apb_strb;
    logic [2:0]  apb_prot;
    logic [31:0] apb_rdata;
    logic        apb_ready;
    logic        apb_slverr;
    logic        apb_active;

    int n_chk = 0;
    int n_err = 0;
    int ratio = 1;
    logic [3:0] pc_cnt;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           pc_cnt <= '0;
        else if (32'(pc_cnt) >= ratio - 1)    pc_cnt <= '0;
        else                                  pc_cnt <= pc_cnt + 4'd1;
    end
    assign pclk_en = rst_n && (32'(pc_cnt) >= ratio - 1);

    assign ahb_ready_in = ahb_readyout;

    ahb_apb_bridge u_ahb_apb_bridge (
        .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en),
        .ahb_sel(ahb_sel), .ahb_addr(ahb_addr), .ahb_trans(ahb_trans),
        .ahb_size(ahb_size), .ahb_prot(ahb_prot), .ahb_write(ahb_write),
        .ahb_ready_in(ahb_ready_in), .ahb_wdata(ahb_wdata),
        .ahb_readyout(ahb_readyout), .ahb_rdata(ahb_rdata), .ahb_resp(ahb_resp),
        .apb_addr(apb_addr), .apb_sel(apb_sel), .apb_enable(apb_enable),
        .apb_write(apb_write), .apb_wdata(apb_wdata), .apb_strb(apb_strb),
        .apb_prot(apb_prot), .apb_rdata(apb_rdata), .apb_ready(apb_ready),
        .apb_slverr(apb_slverr), .apb_active(apb_active)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit wr, input logic [15:0] addr, input logic [2:0] size,
                        input logic [1:0] prot, input logic [31:0] wd, input int waits,
                        input bit err, input logic [31:0] rd);
        logic [3:0] exp_strb;
        logic [2:0] exp_prot;
        int  bytes;
        int  k = 0;
        int  guard = 0;
        bit  done = 1'b0;
        bit  setup_seen = 1'b0;
        bit  seq_ok = 1'b1;
        bit  hold_ok = 1'b1;
        bit  acc_ok = 1'b1;
        bit  prev_sel = 1'b0;
        bit  prev_en = 1'b0;
        bit  prev_pen = 1'b1;
        bytes = 1 << size;
        if (!wr)           exp_strb = 4'b0000;
        else if (size >= 2) exp_strb = 4'b1111;
        else               exp_strb = 4'(((1 << bytes) - 1) << (int'(addr[1:0]) & ~(bytes - 1)));
        exp_prot = {~prot[0], 1'b0, prot[1]};

        @(negedge clk);
        ahb_sel = 1'b1; ahb_trans = 2'b10; ahb_addr = addr;
        ahb_size = size; ahb_prot = prot; ahb_write = wr;
        @(negedge clk);
        ahb_sel = 1'b0; ahb_trans = 2'b00; ahb_wdata = wd;
        chk(!ahb_readyout, "R1 stall after accept", 32'(ahb_readyout), 32'd0);
        chk(apb_active, "R11 active when pending", 32'(apb_active), 32'd1);

        while (!done && guard < 400) begin
            guard++;
            if ((apb_sel != prev_sel || apb_enable != prev_en) && !prev_pen) seq_ok = 1'b0;
            if (prev_en && !apb_enable) acc_ok = 1'b0;
            if (apb_enable && !setup_seen) seq_ok = 1'b0;
            if (ahb_readyout) hold_ok = 1'b0;
            if (apb_sel && !apb_enable && !setup_seen) begin
                setup_seen = 1'b1;
                chk(apb_addr == {addr[15:2], 2'b00}, "R4 address", 32'(apb_addr), 32'({addr[15:2], 2'b00}));
                chk(apb_write == wr, "R4 direction", 32'(apb_write), 32'(wr));
                chk(apb_strb == exp_strb, wr ? "R5 write strobe" : "R6 read strobe",
                    32'(apb_strb), 32'(exp_strb));
                chk(apb_prot == exp_prot, "R7 protection", 32'(apb_prot), 32'(exp_prot));
                if (wr) chk(apb_wdata == wd, "R10 write data", apb_wdata, wd);
            end
            if (apb_enable && pclk_en) begin
                apb_ready  = (k == waits);
                apb_slverr = err && (k == waits);
                apb_rdata  = rd;
                if (k == waits) done = 1'b1;
                k++;
            end else begin
                apb_ready  = 1'b0;
                apb_slverr = 1'b0;
            end
            prev_sel = apb_sel;
            prev_en  = apb_enable;
            prev_pen = pclk_en;
            if (!done) @(negedge clk);
        end

        @(negedge clk);
        apb_ready = 1'b0; apb_slverr = 1'b0;
        chk(done && seq_ok && !apb_sel, "R2 setup/access pacing", 32'(seq_ok), 32'd1);
        chk(acc_ok, "R3 access held until ready", 32'(acc_ok), 32'd1);
        chk(hold_ok, "R1 stalled until completion", 32'(hold_ok), 32'd1);
        if (!err) begin
            chk(ahb_readyout && !ahb_resp, "R8 okay completion", {30'd0, ahb_readyout, ahb_resp}, 32'b10);
            if (!wr) chk(ahb_rdata == rd, "R9 read data", ahb_rdata, rd);
            chk(!apb_active, "R11 idle after completion", 32'(apb_active), 32'd0);
        end else begin
            chk(!ahb_readyout && ahb_resp, "R8 error first cycle", {30'd0, ahb_readyout, ahb_resp}, 32'b01);
            @(negedge clk);
            chk(ahb_readyout && ahb_resp, "R8 error second cycle", {30'd0, ahb_readyout, ahb_resp}, 32'b11);
            @(negedge clk);
            chk(ahb_readyout && !ahb_resp, "R8 error ends", {30'd0, ahb_readyout, ahb_resp}, 32'b10);
        end
    endtask

    task automatic idle_probe(input logic sel, input logic [1:0] trans);
        @(negedge clk);
        ahb_sel = sel; ahb_trans = trans; ahb_addr = 16'h0F0C; ahb_write = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(ahb_readyout && !apb_sel && !apb_active, "R12 not accepted",
                {29'd0, ahb_readyout, apb_sel, apb_active}, 32'b100);
        end
        ahb_sel = 1'b0; ahb_trans = 2'b00;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        ahb_sel = 1'b0; ahb_addr = '0; ahb_trans = 2'b00; ahb_size = '0;
        ahb_prot = '0; ahb_write = 1'b0; ahb_wdata = '0;
        apb_rdata = '0; apb_ready = 1'b0; apb_slverr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ahb_readyout && !ahb_resp, "R1 reset ready", {30'd0, ahb_readyout, ahb_resp}, 32'b10);
        chk(!apb_sel && !apb_enable && !apb_active, "R11 reset idle",
            {29'd0, apb_sel, apb_enable, apb_active}, 32'd0);

        for (int ri = 0; ri < 4; ri++) begin
            ratio = 1 << ri;
            repeat (2) @(negedge clk);
            for (int sz = 0; sz < 3; sz++) begin
                for (int a = 0; a < 4; a++) begin
                    if ((a % (1 << sz)) == 0)
                        xfer(1'b1, {4'(ri + 1), 10'(sz * 37 + a * 5), 2'(a)}, 3'(sz), 2'(a),
                             32'hA5000000 ^ 32'(ri << 8) ^ 32'(a * 3 + sz), (a + sz) % 3, 1'b0, '0);
                end
            end
            for (int p = 0; p < 4; p++) begin
                xfer(1'b0, {4'(ri), 10'(p * 11), 2'(p)}, 3'(p % 3), 2'(p), 32'hFFFF0000,
                     p % 2, 1'b0, 32'hC0DE0000 + 32'(p + ri * 16));
            end
            xfer(1'b1, 16'h4448, 3'd2, 2'b10, 32'h0BAD0BAD, ri % 2, 1'b1, '0);
            xfer(1'b0, 16'h555C, 3'd2, 2'b01, '0, 1, 1'b1, 32'h12345678);
            idle_probe(1'b1, 2'b00);
            idle_probe(1'b0, 2'b10);
            idle_probe(1'b1, 2'b01);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule